// File: doc/BRIEF.md
# Critical Interrupt Arbiter

This block sits beside a small CPU core and decides which of its most urgent interrupt sources is vectored next. Four nonmaskable sources enter it: an undefined-opcode event and a software-trap event, both one-cycle pulses from the decoder; an asynchronous NMI pin; and a one-cycle stack-overflow pulse. A fifth input carries the already-arbitrated request of the ordinary maskable controller, with its vector. The block resolves a fixed priority among them and presents the winner's vector and source code to the CPU. The CPU answers with a one-cycle acknowledge.

The NMI pin is resynchronised through a flop chain and then edge-detected. A held-high pin therefore produces only one request, and no mask or enable stands in its path. Each nonmaskable request is latched until the CPU acknowledges that particular source. After a trap is acknowledged, the block withdraws every request from the CPU until the next instruction retires. This guarantees that one instruction runs between the trap entry and any further interrupt.

Top module: `crit_irq_arbiter`

## Requirements
- R1: After reset, `irq_valid` is 0 and no request is pending.
- R2: Priority from highest to lowest is undefined opcode, trap, NMI, stack overflow, maskable. `irq_src` encodes them as 1, 2, 3, 4 and 5, and 0 means none.
- R3: `irq_vec` carries the winner's vector. By default these are FF2012h for undefined opcode, FF2010h for trap, FF203Eh for NMI and FF203Ch for stack overflow. For the maskable source, `mask_vec` is passed through.
- R4: A rising edge on `nmi_pin` is registered by two flops and then edge-detected. If the pin is first seen high at clock edge k, `irq_valid` with source 3 appears after edge k+2.
- R5: Holding `nmi_pin` high produces exactly one NMI request. A further request needs a low period and then a new rise.
- R6: A latched nonmaskable request stays pending until an acknowledge arrives while that source is the one presented. An `irq_ack` given while `irq_valid` is 0 has no effect.
- R7: Once a trap is acknowledged, `irq_valid` stays 0 until the edge at which `instr_retire` is first seen high after that acknowledge. `irq_valid` reappears after that edge.
- R8: The maskable request is not latched. It is presented only while `mask_req` is high and no nonmaskable request is pending.
- R9: A new pulse of a source in the same cycle as that source's acknowledge leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | One-cycle pulse: trap opcode executed |
| undef_req | input | 1 | One-cycle pulse: undefined opcode met |
| nmi_pin | input | 1 | Asynchronous NMI pin |
| stk_ovf_req | input | 1 | One-cycle pulse: stack bound crossed |
| mask_req | input | 1 | Aggregated maskable request (level) |
| mask_vec | input | VW | Vector of the maskable request |
| irq_ack | input | 1 | CPU acknowledge, one cycle |
| instr_retire | input | 1 | One-cycle pulse per retired instruction |
| irq_valid | output | 1 | A request is presented |
| irq_src | output | 3 | Source code of the presented request |
| irq_vec | output | VW | Vector of the presented request |

## Verification
A wrong pending bit shows up within one cycle as a wrong `irq_src` or `irq_vec`. It can also appear as a request that fails to clear after its acknowledge, or as one that vanishes without an acknowledge. A stuck or early-released inhibit appears as `irq_valid` rising before the retire pulse or staying low after it. A broken synchroniser or edge detector shifts the NMI's first valid cycle away from the third edge, or repeats the request while the pin stays high. A reference model is stepped on every clock and compared against the outputs, so any such divergence is caught in the cycle where it first becomes visible.

// File: rtl/crit_irq_pkg.sv
package crit_irq_pkg;

  localparam int NSRC = 4;  // latched nonmaskable sources

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_UNDEF = 3'd1,
    SRC_TRAP  = 3'd2,
    SRC_NMI   = 3'd3,
    SRC_STK   = 3'd4,
    SRC_MASK  = 3'd5
  } src_e;

  // lowest pending index wins; maskable only when nothing latched
  function automatic src_e pick_src(input logic [NSRC-1:0] pend, input logic mreq);
    src_e s;
    s = mreq ? SRC_MASK : SRC_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) s = src_e'(3'(i + 1));
    end
    return s;
  endfunction

  function automatic logic [31:0] vec_for(input src_e s, input logic [31:0] v_undef,
                                          input logic [31:0] v_trap, input logic [31:0] v_nmi,
                                          input logic [31:0] v_stk, input logic [31:0] v_mask);
    logic [31:0] v;
    case (s)
      SRC_UNDEF: v = v_undef;
      SRC_TRAP:  v = v_trap;
      SRC_NMI:   v = v_nmi;
      SRC_STK:   v = v_stk;
      SRC_MASK:  v = v_mask;
      default:   v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/crit_irq_sync.sv
module crit_irq_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [SYNC_N-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[SYNC_N-2:0], pin};
      prev <= sh[SYNC_N-1];
    end
  end

  assign rise = sh[SYNC_N-1] & ~prev;

  // R5
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/crit_irq_pend.sv
module crit_irq_pend #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= set[i] | (pend[i] & ~clr[i]);
    end

    // R6
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !clr[i]) |=> pend[i]);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> pend[i]);
  end
endmodule

// File: rtl/crit_irq_gate.sv
module crit_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_taken,
  input  logic retire,
  output logic inhibit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          inhibit <= 1'b0;
    else if (trap_taken) inhibit <= 1'b1;
    else if (retire)     inhibit <= 1'b0;
  end

  // R7
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !retire) |=> inhibit);
endmodule

// File: rtl/crit_irq_arbiter.sv
module crit_irq_arbiter
  import crit_irq_pkg::*;
#(
  parameter int unsigned     VW      = 24,
  parameter int              SYNC_N  = 2,
  parameter logic [VW-1:0]   V_UNDEF = 24'hFF2012,
  parameter logic [VW-1:0]   V_TRAP  = 24'hFF2010,
  parameter logic [VW-1:0]   V_NMI   = 24'hFF203E,
  parameter logic [VW-1:0]   V_STK   = 24'hFF203C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trap_req,
  input  logic          undef_req,
  input  logic          nmi_pin,
  input  logic          stk_ovf_req,
  input  logic          mask_req,
  input  logic [VW-1:0] mask_vec,
  input  logic          irq_ack,
  input  logic          instr_retire,
  output logic          irq_valid,
  output logic [2:0]    irq_src,
  output logic [VW-1:0] irq_vec
);
  logic            nmi_rise;
  logic [NSRC-1:0] set_v, clr_v, pend;
  logic            inhibit, ack_fire, trap_taken;
  src_e            sel;
  logic [31:0]     vec_w;

  crit_irq_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(nmi_pin), .rise(nmi_rise));

  assign set_v = {stk_ovf_req, nmi_rise, trap_req, undef_req};

  crit_irq_pend #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .pend(pend));

  assign sel       = pick_src(pend, mask_req);
  assign irq_valid = (sel != SRC_NONE) && !inhibit;
  assign ack_fire  = irq_valid && irq_ack;

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    assign clr_v[i] = ack_fire && (sel == src_e'(3'(i + 1)));
  end

  assign trap_taken = ack_fire && (sel == SRC_TRAP);

  crit_irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .trap_taken(trap_taken),
    .retire(instr_retire), .inhibit(inhibit));

  assign vec_w   = vec_for(sel, 32'(V_UNDEF), 32'(V_TRAP), 32'(V_NMI), 32'(V_STK), 32'(mask_vec));
  assign irq_src = irq_valid ? sel : SRC_NONE;
  assign irq_vec = irq_valid ? vec_w[VW-1:0] : '0;

  // R1
  valid_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((|pend) || mask_req));
  // R2
  undef_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && pend[0]) |-> (irq_src == SRC_UNDEF));
  // R4
  nmi_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_rise |=> pend[2]);
  // R6
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_v));
  // R7
  inhibit_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> !irq_valid);
  // R8
  mask_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && (irq_src == SRC_MASK)) |-> (pend == '0));
endmodule

// File: tb/crit_irq_arbiter_test.sv
module crit_irq_arbiter_test;
  logic        clk = 0, rst_n = 0;
  logic        trap_req = 0, undef_req = 0, nmi_pin = 0, stk_ovf_req = 0;
  logic        mask_req = 0, irq_ack = 0, instr_retire = 0;
  logic [23:0] mask_vec = 24'h00A0B0;
  logic        irq_valid;
  logic [2:0]  irq_src;
  logic [23:0] irq_vec;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  crit_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .undef_req(undef_req),
    .nmi_pin(nmi_pin), .stk_ovf_req(stk_ovf_req), .mask_req(mask_req),
    .mask_vec(mask_vec), .irq_ack(irq_ack), .instr_retire(instr_retire),
    .irq_valid(irq_valid), .irq_src(irq_src), .irq_vec(irq_vec));

  // ---- behavioural reference model ----
  bit m_pend[4];   // index 0 undef, 1 trap, 2 nmi, 3 stack
  int m_s1, m_s2, m_prev;
  bit m_inh;

  function automatic int exp_src();
    for (int k = 0; k < 4; k++) if (m_pend[k]) return k + 1;
    return mask_req ? 5 : 0;
  endfunction

  function automatic int exp_valid();
    return (exp_src() != 0 && !m_inh) ? 1 : 0;
  endfunction

  function automatic logic [23:0] exp_vec(int s);
    case (s)
      1: return 24'hFF2012;
      2: return 24'hFF2010;
      3: return 24'hFF203E;
      4: return 24'hFF203C;
      5: return mask_vec;
      default: return 24'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) m_pend[k] = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_inh = 0;
    end else begin
      int  s, rise;
      bit  fire;
      s    = exp_src();
      fire = (exp_valid() == 1) && irq_ack;
      rise = (m_s2 == 1 && m_prev == 0) ? 1 : 0;
      if (fire && s >= 1 && s <= 4) m_pend[s-1] = 0;
      if (undef_req)   m_pend[0] = 1;
      if (trap_req)    m_pend[1] = 1;
      if (rise == 1)   m_pend[2] = 1;
      if (stk_ovf_req) m_pend[3] = 1;
      if (fire && s == 2) m_inh = 1;
      else if (instr_retire) m_inh = 0;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = nmi_pin ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(int'(irq_valid) == exp_valid(), "R7 valid", int'(irq_valid), exp_valid());
      if (exp_valid() == 1) begin
        chk(int'(irq_src) == exp_src(), "R2 src", int'(irq_src), exp_src());
        chk(irq_vec == exp_vec(exp_src()), "R3 vec", int'(irq_vec), int'(exp_vec(exp_src())));
      end
    end
  end

  task automatic drv(input bit t, input bit u, input bit s, input bit a, input bit r);
    @(negedge clk);
    trap_req = t; undef_req = u; stk_ovf_req = s; irq_ack = a; instr_retire = r;
    @(posedge clk);
    #3;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    drv(0,0,0,0,0);
    // R1 reset state
    chk(irq_valid == 0, "R1 reset", int'(irq_valid), 0);

    // R4 NMI latency: pin high before edge k, valid after k+2
    @(negedge clk); nmi_pin = 1;
    @(posedge clk); #3;
    chk(irq_valid == 0, "R4 edge1", int'(irq_valid), 0);
    drv(0,0,0,0,0);
    chk(irq_valid == 0, "R4 edge2", int'(irq_valid), 0);
    drv(0,0,0,0,0);
    chk(irq_valid == 1 && irq_src == 3, "R4 edge3", int'(irq_src), 3);
    chk(irq_vec == 24'hFF203E, "R3 nmi vec", int'(irq_vec), 24'hFF203E);
    drv(0,0,0,1,0);
    // R5 held high gives no second request
    for (int k = 0; k < 8; k++) drv(0,0,0,0,0);
    chk(irq_valid == 0, "R5 held pin", int'(irq_valid), 0);
    @(negedge clk); nmi_pin = 0;

    // R2 undef and trap together: undef first, then trap
    drv(1,1,0,0,0);
    chk(irq_src == 1, "R2 undef over trap", int'(irq_src), 1);
    drv(0,0,0,1,0);
    chk(irq_src == 2 && irq_vec == 24'hFF2010, "R2 trap next", int'(irq_src), 2);
    // R7 acknowledge trap, then stack overflow stays hidden
    drv(0,0,0,1,0);
    chk(irq_valid == 0, "R7 inhibit", int'(irq_valid), 0);
    drv(0,0,1,0,0);
    chk(irq_valid == 0, "R7 hides stk", int'(irq_valid), 0);
    // R6 ack while not valid is ignored
    drv(0,0,0,1,0);
    drv(0,0,0,0,1);
    chk(irq_valid == 1 && irq_src == 4, "R6 stk kept", int'(irq_src), 4);
    chk(irq_vec == 24'hFF203C, "R3 stk vec", int'(irq_vec), 24'hFF203C);

    // R8 maskable waits for nonmaskable, not latched
    @(negedge clk); mask_req = 1; mask_vec = 24'h123456;
    @(posedge clk); #3;
    chk(irq_src == 4, "R8 stk over mask", int'(irq_src), 4);
    drv(0,0,0,1,0);
    chk(irq_src == 5 && irq_vec == 24'h123456, "R8 mask shown", int'(irq_vec), 24'h123456);
    @(negedge clk); mask_req = 0;
    @(posedge clk); #3;
    chk(irq_valid == 0, "R8 mask dropped", int'(irq_valid), 0);

    // R9 fresh pulse during ack keeps the source
    drv(0,1,0,0,0);
    drv(0,1,0,1,0);
    chk(irq_valid == 1 && irq_src == 1, "R9 set wins", int'(irq_src), 1);
    drv(0,0,0,1,0);
    chk(irq_valid == 0, "R6 cleared by ack", int'(irq_valid), 0);

    // mixed traffic compared against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (($urandom % 7) == 0) nmi_pin = ~nmi_pin;
      if (($urandom % 9) == 0) mask_req = ~mask_req;
      mask_vec = 24'($urandom);
      trap_req     = ($urandom % 13) == 0;
      undef_req    = ($urandom % 29) == 0;
      stk_ovf_req  = ($urandom % 17) == 0;
      irq_ack      = ($urandom % 3) == 0;
      instr_retire = ($urandom % 5) == 0;
    end
    drv(0,0,0,0,0);
    finish_run();
  end
endmodule